// File: doc/BRIEF.md
# Packet-Driven I2C Transfer Sequencer

This block turns an in-band packet stream into a sequence of byte-level I2C bus commands. It takes 32-bit words from a transmit word queue. The first three words of each transfer form a header. The header carries the byte count minus one, the target address and a set of per-transfer flags.

For a write, the block then pulls payload words and sends their bytes least significant first. For a read, it requests bytes from the bit engine and packs the returned bytes into 32-bit words for a receive queue.

At the end of each transfer it applies the end policy chosen in the header: stop, repeated start, or nothing (the next transfer follows directly). It reports completion, NAK errors and lost arbitration as single-cycle pulses. Bit timing, the queues themselves and register access are left to neighbouring blocks.

Top module: `i2c_pkt_parser`

## Requirements
- R1: Each transfer consumes exactly three header words. Word 0 content is ignored. The low LEN_W bits of word 1 hold the byte count minus one, so 0 means one byte. A word is taken only in a cycle where `txPop` and `txValid` are both high.
- R2: In header word 2, bit 7:1 holds a 7-bit address and bits 9:0 hold a 10-bit address. The flag bits are:
  - bit 22: high speed
  - bit 21: continue after NAK
  - bit 20: start byte
  - bit 19: read
  - bit 18: 10-bit addressing
  - bit 17: completion interrupt enable
  - bit 16: end with repeated start
  - bit 15: end with no condition
- R3: Command codes on `cmdOp` are START=1, RESTART=2, STOP=3, ADDR=4, WRITE=5 and READ=6. A 7-bit transfer issues START, then ADDR {addr[7:1], read}, then the data bytes. Write bytes go least significant byte first. A final partial payload word uses only its low-order bytes.
- R4: After the final byte, bit 15 set means no command is issued. Otherwise bit 16 set issues RESTART, and if neither is set the block issues STOP. Bit 15 wins when both are set.
- R5: A read transfer pops no payload words. Each READ carries `cmdData[0]`=1 only on the final byte. Returned bytes are packed least significant first, four per word. A trailing partial word is pushed zero-padded.
- R6: A NAK on an ADDR or WRITE command with bit 21 clear raises `nackErr` for one cycle. In that same cycle the block presents STOP. It then returns to header parsing without `pktDone`.
- R7: With bit 21 set, a NAK is ignored and the transfer completes normally.
- R8: Lost arbitration on any command raises `arbErr` for one cycle. No further command is issued, and the block returns to header parsing.
- R9: A 10-bit write issues ADDR {11110, a[9:8], 0} and then ADDR a[7:0]. A 10-bit read then adds RESTART and ADDR {11110, a[9:8], 1} before the data.
- R10: With bit 20 set, the block issues ADDR 0x01 right after START, ignoring its acknowledge, and then RESTART, before the address.
- R11: If payload is owed while `txValid` is low, the block holds `cmdValid` low and waits. It resumes when a word arrives.
- R12: `pktDone` pulses for one cycle once per completed transfer, after the end condition is accepted. `doneIrq` pulses with it only when bit 17 was set.
- R13: `hsMode` equals bit 22 of the most recent header word 2.
- R14: Once `cmdValid` is raised, `cmdValid`, `cmdOp` and `cmdData` stay stable until the cycle in which `cmdDone` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txWord | input | 32 | Head word of the transmit queue |
| txValid | input | 1 | Transmit queue holds a word |
| txPop | output | 1 | Take the head word this cycle |
| cmdValid | output | 1 | Bus command request |
| cmdOp | output | 3 | Command code (R3) |
| cmdData | output | 8 | Byte to send, or last-byte flag in bit 0 for READ |
| cmdDone | input | 1 | Bit engine finished the command this cycle |
| cmdNack | input | 1 | Byte was not acknowledged (valid with cmdDone) |
| cmdArbLost | input | 1 | Arbitration lost (valid with cmdDone) |
| cmdRdData | input | 8 | Received byte (valid with cmdDone on READ) |
| rxWord | output | 32 | Packed receive word |
| rxPush | output | 1 | Write rxWord into the receive queue |
| pktDone | output | 1 | Transfer completed pulse |
| doneIrq | output | 1 | Completion pulse gated by the interrupt enable flag |
| nackErr | output | 1 | NAK error pulse |
| arbErr | output | 1 | Arbitration-lost pulse |
| hsMode | output | 1 | High-speed flag of the current header |

## Verification
A corrupted byte count or lane index appears within one transfer in one of three ways:
- a missing or extra WRITE/READ command;
- a command with the wrong byte;
- a receive word with bytes in the wrong lanes.

Each of these is visible in the command log as soon as the end condition is issued. A wrong state after a NAK or lost arbitration shows up the next cycle: the wrong command is presented, the block stalls, or the completion pulse is missing. A decode fault in the header flags changes the opening sequence (start byte, 10-bit phases) or the closing command, so the first few commands of a transfer expose it.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

  typedef enum logic [2:0] {
    OP_START   = 3'd1,
    OP_RESTART = 3'd2,
    OP_STOP    = 3'd3,
    OP_ADDR    = 3'd4,
    OP_WRITE   = 3'd5,
    OP_READ    = 3'd6
  } i2cOp_e;

  // header word 2 flag positions
  localparam int F_HS    = 22;
  localparam int F_CNAK  = 21;
  localparam int F_SBYTE = 20;
  localparam int F_RD    = 19;
  localparam int F_TEN   = 18;
  localparam int F_IE    = 17;
  localparam int F_RSTRT = 16;
  localparam int F_CONT  = 15;

  typedef struct packed {
    logic       hs;
    logic       contNak;
    logic       sByte;
    logic       rd;
    logic       ten;
    logic       ie;
    logic       rstrt;
    logic       cont;
    logic [9:0] addr;
  } hdrFlags_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadLen;
    logic loadFlags;
    logic loadWord;
    logic advTx;
    logic capRx;
    logic clear;
  } dpStrobe_t;

endpackage

// File: rtl/i2cp_dp.sv
module i2cp_dp
  import i2cp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         str,
  input  logic [DATA_W-1:0] txWord,
  input  logic [7:0]        rdData,
  output hdrFlags_t         flags,
  output logic              isLast,
  output logic              wordValid,
  output logic [7:0]        txByte,
  output logic [DATA_W-1:0] rxWord,
  output logic              rxPush
);
  localparam int BYTES  = DATA_W / 8;
  localparam int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BYTES - 1);

  logic [LEN_W-1:0]  lenLeft;
  logic [DATA_W-1:0] txWordR;
  logic [DATA_W-1:0] rxAcc;
  logic [DATA_W-1:0] rxAccNext;
  logic [LANE_W-1:0] lane;
  logic              laneEnd;

  assign isLast  = (lenLeft == '0);
  assign laneEnd = (lane == LAST_LANE);
  assign txByte  = txWordR[{lane, 3'b000} +: 8];

  // drop the received byte into its lane
  for (genvar g = 0; g < BYTES; g++) begin : gLane
    assign rxAccNext[8*g +: 8] = (lane == LANE_W'(g)) ? rdData : rxAcc[8*g +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenLeft   <= '0;
      txWordR   <= '0;
      rxAcc     <= '0;
      lane      <= '0;
      wordValid <= 1'b0;
      flags     <= '0;
      rxWord    <= '0;
      rxPush    <= 1'b0;
    end else begin
      rxPush <= 1'b0;
      if (str.clear || str.loadLen) begin
        wordValid <= 1'b0;
        lane      <= '0;
        rxAcc     <= '0;
      end
      if (str.loadLen) lenLeft <= txWord[LEN_W-1:0];
      if (str.loadFlags) begin
        flags.hs      <= txWord[F_HS];
        flags.contNak <= txWord[F_CNAK];
        flags.sByte   <= txWord[F_SBYTE];
        flags.rd      <= txWord[F_RD];
        flags.ten     <= txWord[F_TEN];
        flags.ie      <= txWord[F_IE];
        flags.rstrt   <= txWord[F_RSTRT];
        flags.cont    <= txWord[F_CONT];
        flags.addr    <= txWord[9:0];
      end
      if (str.loadWord) begin
        txWordR   <= txWord;
        wordValid <= 1'b1;
      end
      if (str.advTx) begin
        if (isLast || laneEnd) begin
          wordValid <= 1'b0;
          lane      <= '0;
        end else begin
          lane <= lane + 1'b1;
        end
        if (!isLast) lenLeft <= lenLeft - 1'b1;
      end
      if (str.capRx) begin
        if (isLast || laneEnd) begin
          rxWord <= rxAccNext;
          rxPush <= 1'b1;
          rxAcc  <= '0;
          lane   <= '0;
        end else begin
          rxAcc <= rxAccNext;
          lane  <= lane + 1'b1;
        end
        if (!isLast) lenLeft <= lenLeft - 1'b1;
      end
    end
  end

  // R5
  rx_only_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> flags.rd);

endmodule

// File: rtl/i2cp_ctrl.sv
module i2cp_ctrl
  import i2cp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txValid,
  output logic      txPop,
  output logic      cmdValid,
  output logic [2:0] cmdOp,
  output logic [7:0] cmdData,
  input  logic      cmdDone,
  input  logic      cmdNack,
  input  logic      cmdArbLost,
  input  hdrFlags_t flags,
  input  logic      isLast,
  input  logic      wordValid,
  input  logic [7:0] txByte,
  output dpStrobe_t str,
  output logic      pktDone,
  output logic      nackErr,
  output logic      arbErr
);
  typedef enum logic [3:0] {
    S_H0, S_H1, S_H2, S_START, S_SB, S_SBR, S_A1, S_A2,
    S_AR, S_A3, S_DATA, S_END, S_FIN, S_NSTOP
  } state_e;

  state_e state, nxt;
  i2cOp_e opSel;
  logic   setNack, setArb, nackable, accept;
  logic   unusedFlags;

  assign unusedFlags = flags.hs ^ flags.ie;
  assign cmdOp   = opSel;
  assign accept  = cmdValid && cmdDone;
  assign pktDone = (state == S_FIN);

  always_comb begin
    nxt      = state;
    str      = '0;
    txPop    = 1'b0;
    cmdValid = 1'b0;
    opSel    = OP_START;
    cmdData  = 8'h00;
    nackable = 1'b0;
    setNack  = 1'b0;
    setArb   = 1'b0;
    case (state)
      S_H0: if (txValid) begin txPop = 1'b1; nxt = S_H1; end
      S_H1: if (txValid) begin txPop = 1'b1; str.loadLen = 1'b1; nxt = S_H2; end
      S_H2: if (txValid) begin txPop = 1'b1; str.loadFlags = 1'b1; nxt = S_START; end
      S_START: begin
        cmdValid = 1'b1;
        if (cmdDone) nxt = flags.sByte ? S_SB : S_A1;
      end
      S_SB: begin
        cmdValid = 1'b1; opSel = OP_ADDR; cmdData = 8'h01;
        if (cmdDone) nxt = S_SBR;
      end
      S_SBR: begin
        cmdValid = 1'b1; opSel = OP_RESTART;
        if (cmdDone) nxt = S_A1;
      end
      S_A1: begin
        cmdValid = 1'b1; opSel = OP_ADDR; nackable = 1'b1;
        cmdData  = flags.ten ? {5'b11110, flags.addr[9:8], 1'b0}
                             : {flags.addr[7:1], flags.rd};
        if (cmdDone) nxt = flags.ten ? S_A2 : S_DATA;
      end
      S_A2: begin
        cmdValid = 1'b1; opSel = OP_ADDR; nackable = 1'b1;
        cmdData  = flags.addr[7:0];
        if (cmdDone) nxt = flags.rd ? S_AR : S_DATA;
      end
      S_AR: begin
        cmdValid = 1'b1; opSel = OP_RESTART;
        if (cmdDone) nxt = S_A3;
      end
      S_A3: begin
        cmdValid = 1'b1; opSel = OP_ADDR; nackable = 1'b1;
        cmdData  = {5'b11110, flags.addr[9:8], 1'b1};
        if (cmdDone) nxt = S_DATA;
      end
      S_DATA: begin
        if (flags.rd) begin
          cmdValid = 1'b1; opSel = OP_READ; cmdData = {7'b0, isLast};
          if (cmdDone) begin
            str.capRx = 1'b1;
            if (isLast) nxt = S_END;
          end
        end else if (!wordValid) begin
          if (txValid) begin txPop = 1'b1; str.loadWord = 1'b1; end
        end else begin
          cmdValid = 1'b1; opSel = OP_WRITE; cmdData = txByte; nackable = 1'b1;
          if (cmdDone) begin
            str.advTx = 1'b1;
            if (isLast) nxt = S_END;
          end
        end
      end
      S_END: begin
        if (flags.cont) nxt = S_FIN;
        else begin
          cmdValid = 1'b1;
          opSel    = flags.rstrt ? OP_RESTART : OP_STOP;
          if (cmdDone) nxt = S_FIN;
        end
      end
      S_FIN: nxt = S_H0;
      S_NSTOP: begin
        cmdValid = 1'b1; opSel = OP_STOP;
        if (cmdDone) nxt = S_H0;
      end
      default: nxt = S_H0;
    endcase
    // abort handling overrides the normal path
    if (accept && cmdArbLost) begin
      setArb    = 1'b1;
      nxt       = S_H0;
      str.clear = 1'b1;
      str.capRx = 1'b0;
      str.advTx = 1'b0;
    end else if (accept && cmdNack && nackable && !flags.contNak) begin
      setNack   = 1'b1;
      nxt       = S_NSTOP;
      str.clear = 1'b1;
      str.advTx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_H0;
      nackErr <= 1'b0;
      arbErr  <= 1'b0;
    end else begin
      state   <= nxt;
      nackErr <= setNack;
      arbErr  <= setArb;
    end
  end

  // R14
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdDone) |=> (cmdValid && $stable(cmdOp) && $stable(cmdData)));
  // R1
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> txValid);
  // R5
  rd_no_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DATA && flags.rd) |-> !txPop);
  // R6
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    nackErr |-> (cmdValid && cmdOp == OP_STOP));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |=> !pktDone);
  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pktDone && (nackErr || arbErr)));

endmodule

// File: rtl/i2c_pkt_parser.sv
module i2c_pkt_parser
  import i2cp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txWord,
  input  logic              txValid,
  output logic              txPop,
  output logic              cmdValid,
  output logic [2:0]        cmdOp,
  output logic [7:0]        cmdData,
  input  logic              cmdDone,
  input  logic              cmdNack,
  input  logic              cmdArbLost,
  input  logic [7:0]        cmdRdData,
  output logic [DATA_W-1:0] rxWord,
  output logic              rxPush,
  output logic              pktDone,
  output logic              doneIrq,
  output logic              nackErr,
  output logic              arbErr,
  output logic              hsMode
);
  dpStrobe_t str;
  hdrFlags_t flags;
  logic      isLast, wordValid;
  logic [7:0] txByte;

  i2cp_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txPop(txPop),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .cmdDone(cmdDone), .cmdNack(cmdNack), .cmdArbLost(cmdArbLost),
    .flags(flags), .isLast(isLast), .wordValid(wordValid), .txByte(txByte),
    .str(str), .pktDone(pktDone), .nackErr(nackErr), .arbErr(arbErr)
  );

  i2cp_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) uDp (
    .clk(clk), .rstN(rstN), .str(str), .txWord(txWord), .rdData(cmdRdData),
    .flags(flags), .isLast(isLast), .wordValid(wordValid), .txByte(txByte),
    .rxWord(rxWord), .rxPush(rxPush)
  );

  assign doneIrq = pktDone && flags.ie;
  assign hsMode  = flags.hs;

endmodule

// File: tb/tb_i2c_pkt_parser.sv
module tb_i2c_pkt_parser;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [31:0] txWord;
  logic        txValid, txPop;
  logic        cmdValid;
  logic [2:0]  cmdOp;
  logic [7:0]  cmdData;
  logic        cmdDone = 1'b0, cmdNack = 1'b0, cmdArbLost = 1'b0;
  logic [7:0]  cmdRdData = 8'h00;
  logic [31:0] rxWord;
  logic        rxPush, pktDone, doneIrq, nackErr, arbErr, hsMode;

  i2c_pkt_parser dut (
    .clk(clk), .rstN(rstN), .txWord(txWord), .txValid(txValid), .txPop(txPop),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData), .cmdDone(cmdDone),
    .cmdNack(cmdNack), .cmdArbLost(cmdArbLost), .cmdRdData(cmdRdData),
    .rxWord(rxWord), .rxPush(rxPush), .pktDone(pktDone), .doneIrq(doneIrq),
    .nackErr(nackErr), .arbErr(arbErr), .hsMode(hsMode)
  );

  int total = 0, bad = 0;
  logic finished = 1'b0;

  // transmit queue model
  logic [31:0] fifo [0:63];
  int wrP = 0, rdP = 0;
  assign txValid = (rdP < wrP);
  assign txWord  = fifo[rdP[5:0]];

  // logs
  logic [2:0]  logOp [0:63];
  logic [7:0]  logDat [0:63];
  logic [31:0] rxLog [0:15];
  int logN = 0, rxN = 0, doneN = 0, irqN = 0, nackN = 0, arbN = 0;
  int rdPAtDone = -1, nackIdx = 99, arbIdx = 99, cnt = 0, holdBad = 0;
  logic nackStopOk = 1'b0;
  logic prevPend = 1'b0;
  logic [2:0] prevOp;
  logic [7:0] prevDat;

  // bit engine model: completes each command two cycles after request
  always @(negedge clk) begin
    if (!rstN) begin
      cmdDone = 1'b0; cmdNack = 1'b0; cmdArbLost = 1'b0; cnt = 0; prevPend = 1'b0;
    end else begin
      if (cmdDone) begin
        cmdDone = 1'b0; cmdNack = 1'b0; cmdArbLost = 1'b0; cnt = 0;
      end else if (cmdValid) begin
        cnt++;
        if (cnt >= 2) begin
          cmdDone    = 1'b1;
          cmdNack    = (logN == nackIdx);
          cmdArbLost = (logN == arbIdx);
          cmdRdData  = 8'hB0 + 8'(logN);
        end
      end
      if (nackErr) nackStopOk = cmdValid && cmdOp == 3'd3;
      if (prevPend && !(cmdValid && cmdOp == prevOp && cmdData == prevDat)) holdBad++;
      prevPend = cmdValid && !cmdDone;
      prevOp   = cmdOp;
      prevDat  = cmdData;
    end
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (txPop) rdP <= rdP + 1;
      if (cmdValid && cmdDone) begin
        logOp[logN[5:0]] = cmdOp; logDat[logN[5:0]] = cmdData; logN++;
      end
      if (rxPush) begin rxLog[rxN[3:0]] = rxWord; rxN++; end
      if (pktDone) begin doneN++; rdPAtDone = rdP; end
      if (doneIrq) irqN++;
      if (nackErr) nackN++;
      if (arbErr) arbN++;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkCmd(input int idx, input logic [2:0] op, input logic [7:0] dat, input string tag);
    chk(logOp[idx] == op && logDat[idx] == dat, tag, {21'b0, logOp[idx], logDat[idx]}, {21'b0, op, dat});
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    fifo[wrP[5:0]] = w;
    wrP++;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrP = 0; rdP = 0; logN = 0; rxN = 0; doneN = 0; irqN = 0; nackN = 0; arbN = 0;
    rdPAtDone = -1; nackIdx = 99; arbIdx = 99; nackStopOk = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [31:0] w0();
    return (32'd1 << 16) | (32'd3 << 12) | (32'd1 << 4);
  endfunction

  task automatic header(input int lenM1, input logic [31:0] w2);
    push(w0()); push(32'(lenM1)); push(w2);
  endtask

  task automatic settle(); repeat (80) @(negedge clk); endtask

  task automatic tReset();
    doReset();
    repeat (4) @(negedge clk);
    chk(!cmdValid && !txPop && !pktDone && !rxPush && !nackErr && !arbErr, "R1 reset idle",
        {cmdValid, txPop, pktDone, rxPush}, 0);
  endtask

  task automatic tWrite7();
    doReset();
    header(5, (32'h5A << 1) | (1 << 17) | (1 << 22));
    push(32'h44332211); push(32'h00006655);
    settle();
    chk(logN == 9, "R3 write cmd count", logN, 9);
    chkCmd(0, 3'd1, 8'h00, "R3 start");
    chkCmd(1, 3'd4, 8'hB4, "R2 7-bit address byte");
    for (int i = 0; i < 6; i++) chkCmd(2 + i, 3'd5, 8'(8'h11 * (i + 1)), "R3 lsb-first payload");
    chkCmd(8, 3'd3, 8'h00, "R4 stop end");
    chk(doneN == 1 && irqN == 1, "R12 done and irq", {doneN[15:0], irqN[15:0]}, 32'h00010001);
    chk(hsMode == 1'b1, "R13 hs flag", hsMode, 1);
    chk(rdP == 5, "R1 words consumed", rdP, 5);
  endtask

  task automatic tRead();
    doReset();
    header(4, (32'h33 << 1) | (1 << 19) | (1 << 16));
    push(32'hDEADBEEF);
    settle();
    chk(logN == 8, "R5 read cmd count", logN, 8);
    chkCmd(1, 3'd4, 8'h67, "R2 read address byte");
    for (int i = 0; i < 5; i++) chkCmd(2 + i, 3'd6, (i == 4) ? 8'h01 : 8'h00, "R5 read last marker");
    chkCmd(7, 3'd2, 8'h00, "R4 restart end");
    chk(rxN == 2 && rxLog[0] == 32'hB5B4B3B2, "R5 packed word", rxLog[0], 32'hB5B4B3B2);
    chk(rxLog[1] == 32'h000000B6, "R5 partial word", rxLog[1], 32'h000000B6);
    chk(rdPAtDone == 3, "R5 no payload pop", rdPAtDone, 3);
    chk(irqN == 0 && doneN == 1, "R12 irq gated off", irqN, 0);
    chk(hsMode == 1'b0, "R13 hs clear", hsMode, 0);
  endtask

  task automatic tCont();
    doReset();
    header(0, (32'h21 << 1) | (1 << 15) | (1 << 16));
    push(32'h000000C3);
    settle();
    chk(logN == 3, "R4 continue issues no end command", logN, 3);
    chkCmd(2, 3'd5, 8'hC3, "R4 single byte");
    chk(doneN == 1, "R12 done after continue", doneN, 1);
  endtask

  task automatic tNackAddr();
    doReset();
    nackIdx = 1;
    header(0, 32'h21 << 1);
    settle();
    chk(logN == 3, "R6 nack command count", logN, 3);
    chkCmd(2, 3'd3, 8'h00, "R6 stop after nack");
    chk(nackN == 1 && doneN == 0, "R6 nack error no done", {nackN[15:0], doneN[15:0]}, 32'h00010000);
    chk(nackStopOk, "R6 stop presented with error", nackStopOk, 1);
  endtask

  task automatic tNackCont();
    doReset();
    nackIdx = 2;
    header(1, (32'h21 << 1) | (1 << 21));
    push(32'h0000BBAA);
    settle();
    chk(logN == 5, "R7 continue on nack count", logN, 5);
    chkCmd(3, 3'd5, 8'hBB, "R7 second byte sent");
    chk(nackN == 0 && doneN == 1, "R7 no error", nackN, 0);
  endtask

  task automatic tArb();
    doReset();
    arbIdx = 0;
    header(0, 32'h21 << 1);
    settle();
    chk(logN == 1 && !cmdValid, "R8 no command after arb loss", logN, 1);
    chk(arbN == 1 && doneN == 0, "R8 arb error", arbN, 1);
  endtask

  task automatic tTenRead();
    doReset();
    header(0, 32'h2A5 | (1 << 18) | (1 << 19));
    settle();
    chk(logN == 7, "R9 10-bit read count", logN, 7);
    chkCmd(1, 3'd4, 8'hF4, "R9 high address write");
    chkCmd(2, 3'd4, 8'hA5, "R9 low address");
    chkCmd(3, 3'd2, 8'h00, "R9 restart");
    chkCmd(4, 3'd4, 8'hF5, "R9 high address read");
    chkCmd(5, 3'd6, 8'h01, "R9 single read");
    chk(rxN == 1 && rxLog[0] == 32'h000000B5, "R9 received word", rxLog[0], 32'h000000B5);
  endtask

  task automatic tStartByte();
    doReset();
    nackIdx = 1;
    header(0, (32'h10 << 1) | (1 << 20));
    push(32'h0000007E);
    settle();
    chk(logN == 6, "R10 start byte count", logN, 6);
    chkCmd(1, 3'd4, 8'h01, "R10 start byte");
    chkCmd(2, 3'd2, 8'h00, "R10 restart after start byte");
    chkCmd(3, 3'd4, 8'h20, "R10 address");
    chk(nackN == 0 && doneN == 1, "R10 start byte ack ignored", nackN, 0);
  endtask

  task automatic tStall();
    doReset();
    header(7, 32'h21 << 1);
    push(32'h04030201);
    repeat (60) @(negedge clk);
    chk(logN == 6 && !cmdValid && doneN == 0, "R11 stalled on empty queue", logN, 6);
    push(32'h08070605);
    settle();
    chk(logN == 11, "R11 resumed", logN, 11);
    chkCmd(9, 3'd5, 8'h08, "R11 last byte after stall");
    chkCmd(10, 3'd3, 8'h00, "R11 stop");
    chk(doneN == 1, "R11 done", doneN, 1);
    chk(holdBad == 0, "R14 request stable until done", holdBad, 0);
  endtask

  initial begin
    tReset();
    tWrite7();
    tRead();
    tCont();
    tNackAddr();
    tNackCont();
    tArb();
    tTenRead();
    tStartByte();
    tStall();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule